// File: doc/BRIEF.md
# DDR SDRAM Power-Up Sequencer

This block drives a DDR SDRAM device through its power-up procedure from the controller side. After reset it holds the clock-enable low while the clock runs. The length of that hold is a cycle count worked out from a clock-frequency parameter and a wait-time parameter. It then raises clock-enable on a no-operation cycle. Next it steps through a fixed command list: a first precharge of all banks, an extended mode load that turns the DLL on, a mode load that resets the DLL, a second precharge of all banks, a run of auto-refresh commands, and a final mode load that sets the working mode with the DLL-reset bit cleared.

Each command lasts one cycle. The gap to the next command comes from the timing parameter of the command just sent: the precharge period, the refresh cycle time, or the mode-register cycle time. A second counter starts when the DLL-reset load is sent and measures the DLL lock time. The ready flag rises only after both the last mode-register cycle time and the lock time have passed. Every cycle that carries no command shows a no-operation code. A normal memory controller takes over the bus once the ready flag is high.

Top module: `ddr_init_seq`

## Requirements
- R1: After reset, `cke` stays low for exactly CLK_MHZ*PWRUP_US cycles. It then rises on a cycle that carries a no-operation and stays high until the next reset.
- R2: `cmd_n` carries {chip-select, row-strobe, column-strobe, write-enable}, all active low. No-operation is 4'b0111, precharge is 4'b0010, auto refresh is 4'b0001 and mode-register load is 4'b0000.
- R3: Commands come in this order and no other commands appear: precharge, load with `ba`=1, load with `ba`=0, precharge, N_REF refreshes, load with `ba`=0.
- R4: Each precharge drives `addr` with only bit AP_BIT (default 8) set and `ba`=0. Each refresh drives `addr`=0 and `ba`=0.
- R5: The extended load drives `ba`=1 and `addr`=EXT_WORD, and bit 0 of `addr` is low, which enables the DLL.
- R6: The DLL-reset load drives MODE_WORD with bit DLL_RST_BIT (default 8) forced high. The final load drives MODE_WORD with that bit low.
- R7: The first precharge comes one cycle after `cke` rises. After that, the next command follows a precharge by exactly T_RP cycles, a load by exactly T_MRD cycles and a refresh by exactly T_RFC cycles.
- R8: If the DLL-reset load is at cycle d and the final load is at cycle f, `init_done` first goes high at cycle max(f+T_MRD, d+DLL_LOCK)+1. From then on it stays high with `cke` high and no-operation on `cmd_n` until reset.
- R9: Every cycle that does not carry one of the commands in R3 shows no-operation.
- R10: Reset, whether applied in the middle of the run or after it, forces `cke` low, `init_done` low and no-operation, and the whole sequence restarts from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | output | 1 | Clock enable to the memory |
| cmd_n | output | 4 | {cs_n, ras_n, cas_n, we_n} command code |
| ba | output | BANK_W | Bank select |
| addr | output | ADDR_W | Multiplexed address / mode word |
| init_done | output | 1 | Sequence complete, bus may be handed over |

## Verification
The hardest case to reach is the one where the lock counter, and not the mode-register gap, decides when `init_done` rises. With the default timing the lock time always dominates, so the other branch of R8 never shows up. The bench therefore runs a second instance next to the first, with a short lock time and an extra refresh, and checks the exact rise cycle in both instances. A reset in the middle of the run then shows that the restarted sequence follows the same timeline as the first one.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

   // Command code order: {cs_n, ras_n, cas_n, we_n}
   localparam logic [3:0] CMD_NOP = 4'b0111;
   localparam logic [3:0] CMD_PRE = 4'b0010;
   localparam logic [3:0] CMD_REF = 4'b0001;
   localparam logic [3:0] CMD_LMR = 4'b0000;

   typedef enum logic [3:0] {
      ST_PWRUP   = 4'd0,
      ST_CKE     = 4'd1,
      ST_PREA1   = 4'd2,
      ST_EMRS    = 4'd3,
      ST_MRS_DLL = 4'd4,
      ST_PREA2   = 4'd5,
      ST_REF     = 4'd6,
      ST_MRS_OP  = 4'd7,
      ST_SETTLE  = 4'd8,
      ST_DONE    = 4'd9
   } init_step_e;

endpackage

// File: rtl/ddr_init_downcnt.sv
module ddr_init_downcnt #(
   parameter int unsigned W       = 8,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= RST_VAL;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/ddr_init_cmdgen.sv
module ddr_init_cmdgen
   import ddr_init_pkg::*;
#(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned BANK_W      = 2,
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned T_RP        = 4,
   parameter int unsigned T_RFC       = 14,
   parameter int unsigned T_MRD       = 2,
   parameter int unsigned AP_BIT      = 8,
   parameter int unsigned DLL_RST_BIT = 8,
   parameter logic [ADDR_W-1:0] MODE_WORD = '0,
   parameter logic [ADDR_W-1:0] EXT_WORD  = '0
) (
   input  init_step_e        step,
   input  logic              fire,
   output logic [3:0]        cmd_n,
   output logic [BANK_W-1:0] ba,
   output logic [ADDR_W-1:0] addr,
   output logic [CNT_W-1:0]  gap
);

   localparam logic [CNT_W-1:0] GAP_RP  = CNT_W'(T_RP - 1);
   localparam logic [CNT_W-1:0] GAP_RFC = CNT_W'(T_RFC - 1);
   localparam logic [CNT_W-1:0] GAP_MRD = CNT_W'(T_MRD - 1);
   localparam logic [BANK_W-1:0] BA_EXT = BANK_W'(1);

   logic [ADDR_W-1:0] ap_word;
   logic [ADDR_W-1:0] dll_rst_word;
   logic [ADDR_W-1:0] op_word;

   always_comb begin
      ap_word              = '0;
      ap_word[AP_BIT]      = 1'b1;
      dll_rst_word         = MODE_WORD;
      dll_rst_word[DLL_RST_BIT] = 1'b1;
      op_word              = MODE_WORD;
      op_word[DLL_RST_BIT] = 1'b0;
   end

   always_comb begin
      cmd_n = CMD_NOP;
      ba    = '0;
      addr  = '0;
      gap   = '0;
      if (fire) begin
         unique case (step)
            ST_PREA1, ST_PREA2: begin
               cmd_n = CMD_PRE;
               addr  = ap_word;
               gap   = GAP_RP;
            end
            ST_EMRS: begin
               cmd_n = CMD_LMR;
               ba    = BA_EXT;
               addr  = EXT_WORD;
               gap   = GAP_MRD;
            end
            ST_MRS_DLL: begin
               cmd_n = CMD_LMR;
               addr  = dll_rst_word;
               gap   = GAP_MRD;
            end
            ST_REF: begin
               cmd_n = CMD_REF;
               gap   = GAP_RFC;
            end
            ST_MRS_OP: begin
               cmd_n = CMD_LMR;
               addr  = op_word;
               gap   = GAP_MRD;
            end
            default: begin
               cmd_n = CMD_NOP;
               gap   = '0;
            end
         endcase
      end
   end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
   import ddr_init_pkg::*;
#(
   parameter int unsigned CLK_MHZ     = 200,
   parameter int unsigned PWRUP_US    = 200,
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned BANK_W      = 2,
   parameter int unsigned T_RP        = 4,
   parameter int unsigned T_RFC       = 14,
   parameter int unsigned T_MRD       = 2,
   parameter int unsigned N_REF       = 2,
   parameter int unsigned DLL_LOCK    = 200,
   parameter int unsigned AP_BIT      = 8,
   parameter int unsigned DLL_RST_BIT = 8,
   parameter logic [ADDR_W-1:0] MODE_WORD = 12'h032,
   parameter logic [ADDR_W-1:0] EXT_WORD  = 12'h000
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              cke,
   output logic [3:0]        cmd_n,
   output logic [BANK_W-1:0] ba,
   output logic [ADDR_W-1:0] addr,
   output logic              init_done
);

   localparam int unsigned PWRUP_CYC = CLK_MHZ * PWRUP_US;
   localparam int unsigned GAP_A   = (T_RP > T_RFC) ? T_RP : T_RFC;
   localparam int unsigned GAP_B   = (GAP_A > T_MRD) ? GAP_A : T_MRD;
   localparam int unsigned GAP_MAX = (GAP_B > PWRUP_CYC) ? GAP_B : PWRUP_CYC;
   localparam int unsigned CNT_W   = $clog2(GAP_MAX + 1);
   localparam int unsigned LOCK_W  = (DLL_LOCK > 1) ? $clog2(DLL_LOCK + 1) : 1;
   localparam int unsigned REF_W   = $clog2(N_REF + 1);
   localparam logic [CNT_W-1:0]  PWRUP_LOAD = CNT_W'(PWRUP_CYC - 1);
   localparam logic [REF_W-1:0]  REF_LOAD   = REF_W'(N_REF - 1);

   // elaboration-time parameter checks
   if (PWRUP_CYC < 1) begin : g_bad_pwrup
      $error("power-up wait must be at least one cycle");
   end
   if (N_REF < 2) begin : g_bad_nref
      $error("at least two refresh commands are required");
   end
   if (T_RP < 1 || T_RFC < 1 || T_MRD < 1) begin : g_bad_gap
      $error("command gaps must be at least one cycle");
   end
   if (AP_BIT >= ADDR_W || DLL_RST_BIT >= ADDR_W) begin : g_bad_bit
      $error("address bit position outside the address bus");
   end
   if (EXT_WORD[0] != 1'b0) begin : g_bad_ext
      $error("extended word must keep the DLL enabled");
   end
   if (BANK_W < 1) begin : g_bad_bank
      $error("bank select must be at least one bit wide");
   end

   init_step_e        step_q;
   logic [REF_W-1:0]  ref_left_q;
   logic              main_zero;
   logic              lock_zero;
   logic              fire;
   logic              lock_load;
   logic [CNT_W-1:0]  gap;

   assign fire = main_zero && (step_q != ST_SETTLE) && (step_q != ST_DONE);
   assign lock_load = fire && (step_q == ST_MRS_DLL);

   ddr_init_downcnt #(
      .W       (CNT_W),
      .RST_VAL (PWRUP_LOAD)
   ) u_gap_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (fire),
      .load_val (gap),
      .zero     (main_zero)
   );

   // variant: a lock timer only when a lock time is requested
   if (DLL_LOCK > 0) begin : g_lock
      ddr_init_downcnt #(
         .W       (LOCK_W),
         .RST_VAL ('0)
      ) u_lock_cnt (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (lock_load),
         .load_val (LOCK_W'(DLL_LOCK - 1)),
         .zero     (lock_zero)
      );
   end else begin : g_no_lock
      assign lock_zero = 1'b1;
   end

   ddr_init_cmdgen #(
      .ADDR_W      (ADDR_W),
      .BANK_W      (BANK_W),
      .CNT_W       (CNT_W),
      .T_RP        (T_RP),
      .T_RFC       (T_RFC),
      .T_MRD       (T_MRD),
      .AP_BIT      (AP_BIT),
      .DLL_RST_BIT (DLL_RST_BIT),
      .MODE_WORD   (MODE_WORD),
      .EXT_WORD    (EXT_WORD)
   ) u_cmdgen (
      .step  (step_q),
      .fire  (fire),
      .cmd_n (cmd_n),
      .ba    (ba),
      .addr  (addr),
      .gap   (gap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q     <= ST_PWRUP;
         ref_left_q <= REF_LOAD;
      end else if (fire) begin
         unique case (step_q)
            ST_PWRUP:   step_q <= ST_CKE;
            ST_CKE:     step_q <= ST_PREA1;
            ST_PREA1:   step_q <= ST_EMRS;
            ST_EMRS:    step_q <= ST_MRS_DLL;
            ST_MRS_DLL: step_q <= ST_PREA2;
            ST_PREA2:   step_q <= ST_REF;
            ST_REF: begin
               if (ref_left_q == '0) begin
                  step_q <= ST_MRS_OP;
               end else begin
                  ref_left_q <= ref_left_q - 1'b1;
               end
            end
            ST_MRS_OP:  step_q <= ST_SETTLE;
            default:    step_q <= step_q;
         endcase
      end else if (step_q == ST_SETTLE && main_zero && lock_zero) begin
         step_q <= ST_DONE;
      end
   end

   assign cke       = (step_q != ST_PWRUP);
   assign init_done = (step_q == ST_DONE);

endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
   parameter int unsigned PWRUP_CYC   = 40000,
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned BANK_W      = 2,
   parameter int unsigned T_RP        = 4,
   parameter int unsigned T_RFC       = 14,
   parameter int unsigned T_MRD       = 2,
   parameter int unsigned DLL_RST_BIT = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cke,
   input logic [3:0]        cmd_n,
   input logic [BANK_W-1:0] ba,
   input logic [ADDR_W-1:0] addr,
   input logic              init_done
);

   localparam logic [3:0] C_NOP = 4'b0111;
   localparam logic [3:0] C_PRE = 4'b0010;
   localparam logic [3:0] C_REF = 4'b0001;
   localparam logic [3:0] C_LMR = 4'b0000;

   logic [31:0] low_cnt;
   logic [31:0] since;
   logic [31:0] need;
   logic [3:0]  last_cmd;
   logic        have_last;
   logic        last_a8;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt   <= '0;
         since     <= '0;
         last_cmd  <= C_NOP;
         have_last <= 1'b0;
         last_a8   <= 1'b0;
      end else begin
         if (!cke && low_cnt != '1) low_cnt <= low_cnt + 1;
         if (cmd_n != C_NOP) begin
            since     <= 32'd1;
            last_cmd  <= cmd_n;
            have_last <= 1'b1;
            last_a8   <= addr[DLL_RST_BIT];
         end else if (since != '1) begin
            since <= since + 1;
         end
      end
   end

   always_comb begin
      unique case (last_cmd)
         C_PRE:   need = T_RP;
         C_REF:   need = T_RFC;
         C_LMR:   need = T_MRD;
         default: need = 32'd0;
      endcase
   end

   assert_cke_wait_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cke) |-> (low_cnt == PWRUP_CYC));

   assert_cke_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cke |=> cke);

   assert_nop_while_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |-> (cmd_n == C_NOP));

   assert_first_is_pre_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_n != C_NOP && !have_last) |-> (cmd_n == C_PRE));

   assert_gap_exact_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_n != C_NOP && have_last) |-> (since == need));

   assert_ext_dll_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_n == C_LMR && ba == BANK_W'(1)) |-> (addr[0] == 1'b0));

   assert_final_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_done) |-> (last_cmd == C_LMR && !last_a8));

   assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);

   assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |-> (cke && cmd_n == C_NOP));

endmodule

bind ddr_init_seq ddr_init_seq_chk #(
   .PWRUP_CYC   (CLK_MHZ * PWRUP_US),
   .ADDR_W      (ADDR_W),
   .BANK_W      (BANK_W),
   .T_RP        (T_RP),
   .T_RFC       (T_RFC),
   .T_MRD       (T_MRD),
   .DLL_RST_BIT (DLL_RST_BIT)
) u_ddr_init_seq_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cke       (cke),
   .cmd_n     (cmd_n),
   .ba        (ba),
   .addr      (addr),
   .init_done (init_done)
);

// File: tb/ddr_init_seq_bench.sv
`timescale 1ns/1ps
module ddr_init_seq_bench;
   import ddr_init_pkg::*;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   int cyc = 0;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   logic        cke_a, done_a, cke_b, done_b;
   logic [3:0]  cmd_a, cmd_b;
   logic [1:0]  ba_a, ba_b;
   logic [11:0] addr_a, addr_b;

   // main instance: 20-cycle power-up, 200-cycle lock dominates
   ddr_init_seq #(
      .CLK_MHZ(1), .PWRUP_US(20), .T_RP(4), .T_RFC(14), .T_MRD(2),
      .N_REF(2), .DLL_LOCK(200), .MODE_WORD(12'h032), .EXT_WORD(12'h000)
   ) u_ddr_init_seq (
      .clk(clk), .rst_n(rst_n), .cke(cke_a), .cmd_n(cmd_a),
      .ba(ba_a), .addr(addr_a), .init_done(done_a)
   );

   // second instance: short lock, three refreshes, gap dominates
   ddr_init_seq #(
      .CLK_MHZ(1), .PWRUP_US(10), .T_RP(4), .T_RFC(14), .T_MRD(2),
      .N_REF(3), .DLL_LOCK(8), .MODE_WORD(12'h063), .EXT_WORD(12'h002)
   ) u_ddr_init_seq_alt (
      .clk(clk), .rst_n(rst_n), .cke(cke_b), .cmd_n(cmd_b),
      .ba(ba_b), .addr(addr_b), .init_done(done_b)
   );

   typedef struct packed {
      logic [15:0] at;
      logic [3:0]  cmd;
      logic [1:0]  ba;
      logic [11:0] addr;
   } ev_t;

   typedef struct packed {
      logic inst;
      ev_t  ev;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VEC [NV] = '{
      '{1'b0, '{16'd21, CMD_PRE, 2'd0, 12'h100}},
      '{1'b0, '{16'd25, CMD_LMR, 2'd1, 12'h000}},
      '{1'b0, '{16'd27, CMD_LMR, 2'd0, 12'h132}},
      '{1'b0, '{16'd29, CMD_PRE, 2'd0, 12'h100}},
      '{1'b0, '{16'd33, CMD_REF, 2'd0, 12'h000}},
      '{1'b0, '{16'd47, CMD_REF, 2'd0, 12'h000}},
      '{1'b0, '{16'd61, CMD_LMR, 2'd0, 12'h032}},
      '{1'b1, '{16'd11, CMD_PRE, 2'd0, 12'h100}},
      '{1'b1, '{16'd15, CMD_LMR, 2'd1, 12'h002}},
      '{1'b1, '{16'd17, CMD_LMR, 2'd0, 12'h163}},
      '{1'b1, '{16'd19, CMD_PRE, 2'd0, 12'h100}},
      '{1'b1, '{16'd23, CMD_REF, 2'd0, 12'h000}},
      '{1'b1, '{16'd37, CMD_REF, 2'd0, 12'h000}},
      '{1'b1, '{16'd51, CMD_REF, 2'd0, 12'h000}},
      '{1'b1, '{16'd65, CMD_LMR, 2'd0, 12'h063}}
   };

   ev_t cap_a [16];
   ev_t cap_b [16];
   int  n_a = 0, n_b = 0;
   logic cap_en = 1'b0;

   int checks = 0, errs = 0;
   logic fin = 1'b0;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      while (cyc != n) @(negedge clk);
   endtask

   always @(negedge clk) begin
      if (cap_en && rst_n) begin
         if (cmd_a != CMD_NOP) begin
            if (n_a < 16) cap_a[n_a] = '{16'(cyc), cmd_a, ba_a, addr_a};
            n_a++;
         end
         if (cmd_b != CMD_NOP) begin
            if (n_b < 16) cap_b[n_b] = '{16'(cyc), cmd_b, ba_b, addr_b};
            n_b++;
         end
      end
   end

   initial begin
      #(64'd4_000_000);
      if (!fin) begin
         checks++;
         errs++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 16; i++) begin
         cap_a[i] = '0;
         cap_b[i] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n  = 1'b1;
      cap_en = 1'b1;

      // reset state, R1 / R10
      chk("R1", "cke at cycle 0", int'(cke_a), 0);
      chk("R9", "cmd at cycle 0", int'(cmd_a), int'(CMD_NOP));
      chk("R10", "init_done at cycle 0", int'(done_a), 0);

      wait_cyc(9);
      chk("R1", "alt cke before wait end", int'(cke_b), 0);
      wait_cyc(10);
      chk("R1", "alt cke rises", int'(cke_b), 1);
      wait_cyc(19);
      chk("R1", "cke before wait end", int'(cke_a), 0);
      wait_cyc(20);
      chk("R1", "cke rises", int'(cke_a), 1);
      chk("R1", "nop on cke rise", int'(cmd_a), int'(CMD_NOP));

      // gap-limited finish on the alternate instance, R8
      wait_cyc(67);
      chk("R8", "alt init_done early", int'(done_b), 0);
      wait_cyc(68);
      chk("R8", "alt init_done rise", int'(done_b), 1);

      // lock-limited finish on the main instance, R8
      wait_cyc(227);
      chk("R8", "init_done early", int'(done_a), 0);
      wait_cyc(228);
      chk("R8", "init_done rise", int'(done_a), 1);

      wait_cyc(240);
      chk("R8", "init_done held", int'(done_a), 1);
      chk("R8", "nop after done", int'(cmd_a), int'(CMD_NOP));
      chk("R8", "alt init_done held", int'(done_b), 1);
      chk("R3", "command count", n_a, 7);
      chk("R3", "alt command count", n_b, 8);

      // walk the expected command table: R2..R7
      begin
         int ia = 0;
         int ib = 0;
         for (int i = 0; i < NV; i++) begin
            ev_t want;
            ev_t got;
            string atag;
            want = VEC[i].ev;
            if (VEC[i].inst) begin
               got = cap_b[ib];
               ib++;
            end else begin
               got = cap_a[ia];
               ia++;
            end
            if (want.cmd != CMD_LMR) atag = "R4";
            else if (want.ba == 2'd1) atag = "R5";
            else atag = "R6";
            chk("R7", $sformatf("cycle of entry %0d", i), int'(got.at), int'(want.at));
            chk("R2", $sformatf("code of entry %0d", i), int'(got.cmd), int'(want.cmd));
            chk(atag, $sformatf("bank of entry %0d", i), int'(got.ba), int'(want.ba));
            chk(atag, $sformatf("addr of entry %0d", i), int'(got.addr), int'(want.addr));
         end
      end

      // reset after completion, then restart, R10
      cap_en = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      chk("R10", "cke in reset", int'(cke_a), 0);
      chk("R10", "init_done in reset", int'(done_a), 0);
      chk("R10", "alt init_done in reset", int'(done_b), 0);
      chk("R10", "nop in reset", int'(cmd_a), int'(CMD_NOP));
      rst_n = 1'b1;
      wait_cyc(19);
      chk("R10", "cke low after restart", int'(cke_a), 0);
      wait_cyc(21);
      chk("R10", "first precharge after restart", int'(cmd_a), int'(CMD_PRE));

      // reset in the middle of the run, R10
      wait_cyc(40);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R10", "cke after mid reset", int'(cke_a), 0);
      chk("R10", "nop after mid reset", int'(cmd_a), int'(CMD_NOP));
      rst_n = 1'b1;
      wait_cyc(25);
      chk("R10", "extended load after mid reset", int'(cmd_a), int'(CMD_LMR));
      chk("R10", "extended bank after mid reset", int'(ba_a), 1);

      fin = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule